// File: doc/BRIEF.md
# Memory Request Handshake Controller

This block sits between a control unit that updates its control signals on the rising clock edge and a memory that may need one clock cycle or several to finish a transfer. The control unit issues read and write requests as single-cycle pulses. The block turns each pulse into a held memory request that stays up until the memory answers with its completion flag. The held request is re-registered on the falling edge, so it reaches memory in the same half-cycle as the address, which is also captured on the falling edge.

The block also owns the control step counter. The counter advances once per rising edge. It freezes while a wait-for-completion step has an outstanding request that the memory has not yet finished. An end-of-sequence input returns the counter to the first step. The stall is a synchronous enable on the counter, not a gated clock.

A timing effect follows from this structure. A request pulse that arrives in the step right after a wait-for-completion step is masked while the completion flag is still high. It therefore reaches memory one cycle late, in the next step.

Top module: `mem_handshake_ctrl`

## Requirements
- R1: Once a read (or write) request is held and `mem_done` is 0, it stays held on every following rising edge until `mem_done` is seen as 1.
- R2: A request pulse with `mem_done` at 0 raises `mem_rd` (or `mem_wr`) at the falling edge of the same cycle. `mem_addr` takes `addr_in` at every falling edge where `addr_ld` is 1, and otherwise keeps its value.
- R3: When `mem_done` is 1 at a rising edge and no new pulse is present, the held request clears. `mem_rd`/`mem_wr` then fall at the next falling edge.
- R4: `run` is 0 exactly when a request is held, `mem_done` is 0 and `wait_done` is 1. In every other case `run` is 1.
- R5: `step` resets to 0, the first step. It increments by 1 (wrapping) on a rising edge where `run` is 1, and holds its value when `run` is 0.
- R6: With `step_end` at 1 and `run` at 1, the next rising edge loads `step` with 0.
- R7: A request pulse is masked while `mem_done` is 1. A pulse issued in the step right after a completed wait-for-completion step therefore shows on `mem_rd`/`mem_wr` one cycle later, in the next step.
- R8: `wait_done` may share a step with a read or write pulse. That step stalls from its own cycle until completion.
- R9: If a pulse and `mem_done` are both 1 at a rising edge, the hold register toggles. A hold that was clear becomes set, and the request then stays held.
- R10: A synchronous reset (`rst` at 1) clears the hold registers, `mem_rd`, `mem_wr`, `mem_addr` and `step`. The hold registers and `step` clear on the rising edge; `mem_rd`, `mem_wr` and `mem_addr` clear on the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; hold and step logic on rising edge, memory-side registers on falling edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_pulse | input | 1 | Single-cycle read request from the control unit |
| wr_pulse | input | 1 | Single-cycle write request from the control unit |
| wait_done | input | 1 | Current step must wait for memory completion |
| step_end | input | 1 | Current step is the last; return to step 0 |
| mem_done | input | 1 | Memory completion flag, changes on falling edge |
| addr_ld | input | 1 | Load `addr_in` into the address register |
| addr_in | input | ADDR_W | Address from the control path |
| mem_rd | output | 1 | Held read request toward memory |
| mem_wr | output | 1 | Held write request toward memory |
| mem_addr | output | ADDR_W | Registered address toward memory |
| run | output | 1 | Step counter enable |
| step | output | STEP_W | Current control step, 0 is the first |

## Verification
The two functions that can meet in one cycle are a fresh request pulse and the memory's completion flag. Both can be present at the same rising edge, where the hold register sees its set and clear terms together. The bench provokes this by driving both by hand and checks that the hold toggles into a set state and keeps `mem_rd` high afterwards. It also counts such cycles as illegal stimulus. The milder form of the overlap is a pulse during the first half-cycle after completion. A directed program (read with wait, write, wait) covers it, and the bench checks per cycle that the write appears one step late. Random programs with latencies of 1 to 8 are compared against a bench-side cycle model.

// File: rtl/mem_handshake_ctrl.sv
module mem_handshake_ctrl #(
  parameter int STEP_W = 3,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_pulse,
  input  logic              wr_pulse,
  input  logic              wait_done,
  input  logic              step_end,
  input  logic              mem_done,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              run,
  output logic [STEP_W-1:0] step
);

  logic rd_hold, wr_hold;
  logic rd_req, wr_req;

  function automatic logic jk_next(input logic q, input logic j, input logic k);
    case ({j, k})
      2'b10:   jk_next = 1'b1;
      2'b01:   jk_next = 1'b0;
      2'b11:   jk_next = ~q;
      default: jk_next = q;
    endcase
  endfunction

  assign rd_req = (rd_pulse & ~mem_done) | rd_hold;
  assign wr_req = (wr_pulse & ~mem_done) | wr_hold;
  assign run    = ~((rd_req | wr_req) & ~mem_done & wait_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hold <= 1'b0;
      wr_hold <= 1'b0;
    end else begin
      rd_hold <= jk_next(rd_hold, rd_pulse, mem_done);
      wr_hold <= jk_next(wr_hold, wr_pulse, mem_done);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      step <= '0;
    else if (run)
      step <= step_end ? '0 : step + 1'b1;
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      mem_rd   <= 1'b0;
      mem_wr   <= 1'b0;
      mem_addr <= '0;
    end else begin
      mem_rd <= rd_req;
      mem_wr <= wr_req;
      if (addr_ld)
        mem_addr <= addr_in;
    end
  end

  assert_read_held_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !mem_done) |=> rd_req);
  assert_write_held_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !mem_done) |=> wr_req);
  assert_read_release_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_done && !rd_pulse) |=> (rd_req == (rd_pulse && !mem_done)));
  assert_run_free_R4: assert property (@(posedge clk) disable iff (rst)
    (!wait_done || mem_done) |-> run);
  assert_stall_R5: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(step));
  assert_end_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (run && step_end) |=> (step == '0));

endmodule

// File: tb/sim_mem_handshake_ctrl.sv
module sim_mem_handshake_ctrl;
  localparam int STEP_W = 3;
  localparam int ADDR_W = 16;

  logic clk = 0, rst = 1;
  logic rd_pulse = 0, wr_pulse = 0, wait_done = 0, step_end = 0, mem_done = 0, addr_ld = 0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic mem_rd, mem_wr, run;
  logic [ADDR_W-1:0] mem_addr;
  logic [STEP_W-1:0] step;

  int checks = 0, fails = 0, illegal = 0;
  bit manual = 0, mem_manual = 0, cmp_en = 0;
  int lat = 1, cnt = 0;
  bit guard = 0;

  // step codes: 0 idle, 1 rd+wait, 2 wr+wait, 3 rd, 4 wr, 5 wait only, 6 end
  int prog [8];
  logic [ADDR_W-1:0] paddr [8];

  // bench model state
  logic mh_r, mh_w, m_mr, m_mw;
  logic [STEP_W-1:0] m_step;
  logic [ADDR_W-1:0] m_addr;

  always #10 clk = ~clk;

  mem_handshake_ctrl #(.STEP_W(STEP_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .rd_pulse(rd_pulse), .wr_pulse(wr_pulse),
    .wait_done(wait_done), .step_end(step_end), .mem_done(mem_done),
    .addr_ld(addr_ld), .addr_in(addr_in), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .run(run), .step(step));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("illegal stimulus cycles seen: %0d", illegal);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  function automatic logic jk(input logic q, input logic j, input logic k);
    return (j & ~k) | (j & k & ~q) | (~j & ~k & q);
  endfunction

  function automatic logic m_run_f();
    logic req;
    req = ((rd_pulse & ~mem_done) | mh_r) | ((wr_pulse & ~mem_done) | mh_w);
    return !(req && !mem_done && wait_done);
  endfunction

  // control unit: decode the current step
  always @(posedge clk) begin
    #2;
    if (!manual) begin
      int c;
      c = prog[step];
      rd_pulse  = (c == 1 || c == 3);
      wr_pulse  = (c == 2 || c == 4);
      wait_done = (c == 1 || c == 2 || c == 5);
      step_end  = (c == 6);
      addr_ld   = rd_pulse | wr_pulse;
      addr_in   = paddr[step];
    end
  end

  // memory with programmable latency
  always @(negedge clk) begin
    if (!mem_manual) begin
      if (mem_done) mem_done <= 1'b0;
      else if (mem_rd || mem_wr) begin
        if (!guard) begin
          cnt = cnt + 1;
          if (cnt >= lat) begin
            mem_done <= 1'b1;
            guard = 1;
            cnt = 0;
          end
        end
      end else guard = 0;
    end
  end

  always @(posedge clk)
    if (!rst && (rd_pulse || wr_pulse) && mem_done && !wait_done) illegal++;

  // cycle model from the requirements
  always @(posedge clk) begin
    if (rst) begin
      mh_r <= 0; mh_w <= 0; m_step <= '0;
    end else begin
      mh_r <= jk(mh_r, rd_pulse, mem_done);
      mh_w <= jk(mh_w, wr_pulse, mem_done);
      if (m_run_f()) m_step <= step_end ? '0 : m_step + 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      m_mr <= 0; m_mw <= 0; m_addr <= '0;
    end else begin
      m_mr <= (rd_pulse & ~mem_done) | mh_r;
      m_mw <= (wr_pulse & ~mem_done) | mh_w;
      if (addr_ld) m_addr <= addr_in;
    end
  end

  always @(negedge clk) begin
    #7;
    if (cmp_en && !rst) begin
      check("R2 R3 model mem_rd", mem_rd, m_mr);
      check("R1 R7 model mem_wr", mem_wr, m_mw);
      check("R5 R6 model step", step, m_step);
      check("R4 R8 model run", run, m_run_f());
      check("R2 model mem_addr", mem_addr, m_addr);
    end
  end

  task automatic late();
    @(negedge clk); #7;
  endtask

  task automatic do_reset();
    cmp_en = 0;
    @(posedge clk); #2 rst = 1;
    repeat (2) @(posedge clk);
    #2 rst = 0;
    cmp_en = 1;
  endtask

  task automatic exp_cyc(input string tag, input int mr, input int mw, input int st, input int rn);
    late();
    check({tag, " mem_rd"}, mem_rd, mr);
    check({tag, " mem_wr"}, mem_wr, mw);
    check({tag, " step"}, step, st);
    check({tag, " run"}, run, rn);
  endtask

  initial begin
    void'($urandom(1234));
    foreach (prog[i]) begin prog[i] = 0; paddr[i] = 16'h1000 + ADDR_W'(i); end
    manual = 1; mem_manual = 1;
    cmp_en = 0;
    repeat (3) @(posedge clk);
    #2 rst = 0;
    @(posedge clk); #2 rst = 1;
    late();
    late();
    check("R10 reset mem_rd", mem_rd, 0);
    check("R10 reset mem_wr", mem_wr, 0);
    check("R10 reset step", step, 0);
    check("R10 reset run", run, 1);
    check("R10 reset mem_addr", mem_addr, 0);

    // directed: rd+wait, wr, wait, end with latency 1
    manual = 0; mem_manual = 0; lat = 1; guard = 0; cnt = 0;
    prog[0] = 1; prog[1] = 4; prog[2] = 5; prog[3] = 6;
    paddr[0] = 16'hA5A5; paddr[1] = 16'h3C3C;
    do_reset();
    exp_cyc("R8 c0", 1, 0, 0, 0);
    check("R2 c0 mem_addr", mem_addr, 16'hA5A5);
    exp_cyc("R1 c1", 1, 0, 0, 1);
    exp_cyc("R7 c2 write masked", 0, 0, 1, 1);
    exp_cyc("R7 c3 write late", 0, 1, 2, 0);
    check("R2 c3 mem_addr", mem_addr, 16'h3C3C);
    exp_cyc("R5 c4", 0, 1, 2, 1);
    exp_cyc("R3 c5", 0, 0, 3, 1);
    exp_cyc("R6 c6", 1, 0, 0, 0);

    // directed: pulse and completion at the same rising edge
    manual = 1; mem_manual = 1;
    rd_pulse = 0; wr_pulse = 0; wait_done = 0; step_end = 0; addr_ld = 0;
    mem_done <= 0;
    do_reset();
    @(negedge clk);
    mem_done <= 1; rd_pulse = 1;
    @(posedge clk); #2 rd_pulse = 0;
    @(negedge clk); mem_done <= 0;
    #7 check("R9 toggle sets hold mem_rd", mem_rd, 1);
    late();
    check("R9 hold persists mem_rd", mem_rd, 1);
    mem_done <= 1;
    late();
    mem_done <= 0;
    late();
    check("R3 cleared mem_rd", mem_rd, 0);

    // random programs
    manual = 0; mem_manual = 0;
    for (int n = 0; n < 60; n++) begin
      int len, i;
      len = 4 + int'($urandom % 5);
      foreach (prog[k]) begin prog[k] = 0; paddr[k] = ADDR_W'($urandom); end
      i = 0;
      while (i < len - 1) begin
        int kind;
        kind = int'($urandom % 5);
        if ((kind == 1 || kind == 2) && i + 2 <= len - 1) begin
          prog[i] = kind; i += 2;
        end else if ((kind == 3 || kind == 4) && i + 3 <= len - 1) begin
          prog[i] = kind; prog[i+1] = 5; i += 3;
        end else i += 1;
      end
      prog[len-1] = 6;
      lat = 1 + int'($urandom % 8);
      mem_done <= 0; guard = 0; cnt = 0;
      do_reset();
      repeat (60 + 10 * lat) @(posedge clk);
    end

    cmp_en = 0;
    late();
    finish_run();
  end
endmodule